// File: doc/BRIEF.md
# Serial Wiper Register Front-End

This block sits between a three-wire serial host link and four 8-bit wiper setting registers. While the chip select, after filtering, is high, the block waits for a start bit. It then takes a 2-bit channel address and 8 data bits, both least significant bit first. As the data bits arrive, it shifts the addressed register's previous contents out on the serial data output. Once the last data bit is in, it loads the new value into that register. Every write is therefore also a destructive read of the addressed register. A host that only wants to read sends a frame and then drops chip select, which puts the stored value back.

Each time the filtered chip select falls, all four volatile registers reload from a non-volatile shadow image presented on a plain input bus. They load the same way at reset, with no serial clock activity. The serial clock, data input and chip select are sampled by a fast system clock. Chip select passes a saturating-counter glitch filter.

The receive state machine has five named states:
- `ST_OFF`: chip select is low.
- `ST_HUNT`: waiting for a start bit.
- `ST_ADDR`: collecting the address bits.
- `ST_DATA`: collecting data bits and shifting out the old value.
- `ST_GAP`: ignoring the idle clocks that must follow a frame.

Its transitions are:
- OFF to HUNT when the filtered select rises.
- HUNT to ADDR on a serial edge that samples a 1.
- ADDR to DATA on the second address edge.
- DATA to GAP on the eighth data edge.
- GAP to HUNT on the second gap edge.
- Any state to OFF when the filtered select is low.

Top module: `wsr_frontend`

## Requirements
- R1: While `rst_n` is low, every system clock edge loads all four wiper registers from `nv_image_i`. No serial clock edge is needed.
- R2: A frame starts with the first serial rising edge that samples `sdi_i` = 1 in `ST_HUNT`; edges that sample 0 there are ignored. The next 2 edges give the address, first bit a0 then a1. The 8 edges after that give the data, bit 0 first.
- R3: The channel index is a0 + 2*a1. Index k selects wiper k+1, which sits at `wiper_o[8*k +: 8]`. So a0a1 = 00 selects wiper 1, 10 selects wiper 2, 01 selects wiper 3 and 11 selects wiper 4.
- R4: After the a1 edge, `sdo_o` shows bit 0 of the addressed register's old value. After data edge i (i = 0..6) it shows old bit i+1.
- R5: The addressed wiper takes the new 8-bit value right after the edge that samples data bit 7. The other three wipers do not change.
- R6: The two serial edges after data bit 7 are ignored whatever `sdi_i` is. The third edge is sampled as in `ST_HUNT`.
- R7: `sdo_oe_o` is 1 exactly while the filtered chip select is high. While it is high, `sdo_o` is 0 outside the readback window.
- R8: When the filtered chip select falls, all four wipers reload from `nv_image_i`, which discards any temporary settings.
- R9: A chip select level change is accepted only after the synchronised input has differed from the filtered level for `CS_FILT` consecutive system cycles (default 4). Shorter pulses have no effect.
- R10: A frame cut off by chip select falling before data bit 7 leaves every wiper at its `nv_image_i` value. The next frame starts from the start-bit hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset, synchronous load of the shadow image |
| sclk_i | input | 1 | Serial bit clock, sampled on its rising edge |
| csel_i | input | 1 | Raw chip select, active high |
| sdi_i | input | 1 | Serial data in |
| nv_image_i | input | 32 | Non-volatile shadow image, wiper k+1 in bits 8k+7..8k |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the tri-state data pin |
| wiper_o | output | 32 | Current wiper settings, same layout as the image |

## Verification
The assertions take for granted that `sclk_i`, `sdi_i` and `csel_i` change far slower than the system clock. Each serial level must be held for several system cycles, so that one serial rising edge gives exactly one sampled event, and `sdi_i` must be steady across that edge. The stimulus drives every serial level for six to eight system cycles and changes `sdi_i` only while `sclk_i` is low. It also waits well past the filter delay after each chip select change, except in the deliberate short-pulse test.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_HUNT,
        ST_ADDR,
        ST_DATA,
        ST_GAP
    } fe_state_t;
endpackage

// File: rtl/wsr_sync_edge.sv
module wsr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic sdi_o
);
    logic [STAGES-1:0] clk_sh;
    logic [STAGES-1:0] dat_sh;
    logic              clk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sh   <= '0;
            dat_sh   <= '0;
            clk_last <= 1'b0;
        end else begin
            clk_sh   <= {clk_sh[STAGES-2:0], sclk_i};
            dat_sh   <= {dat_sh[STAGES-2:0], sdi_i};
            clk_last <= clk_sh[STAGES-1];
        end
    end

    assign rise_o = clk_sh[STAGES-1] & ~clk_last;
    assign sdi_o  = dat_sh[STAGES-1];
endmodule

// File: rtl/wsr_cs_filter.sv
module wsr_cs_filter #(
    parameter int STAGES  = 2,
    parameter int CS_FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csel_i,
    output logic cs_sync_o,
    output logic cs_o,
    output logic fall_o
);
    localparam int CW = $clog2(CS_FILT + 1);

    logic [STAGES-1:0] sh;
    logic [CW-1:0]     run;
    logic              level;
    logic              level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            run     <= '0;
            level   <= 1'b0;
            level_d <= 1'b0;
        end else begin
            sh      <= {sh[STAGES-2:0], csel_i};
            level_d <= level;
            if (sh[STAGES-1] == level) begin
                run <= '0;
            end else if (run == CW'(CS_FILT - 1)) begin
                run   <= '0;
                level <= sh[STAGES-1];
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    assign cs_sync_o = sh[STAGES-1];
    assign cs_o      = level;
    assign fall_o    = level_d & ~level;
endmodule

// File: rtl/wsr_frame_fsm.sv
module wsr_frame_fsm
    import wsr_pkg::*;
#(
    parameter int CH  = 4,
    parameter int DW  = 8,
    parameter int GAP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active_i,
    input  logic                   rise_i,
    input  logic                   sdi_i,
    input  logic [CH*DW-1:0]       bank_i,
    output fe_state_t              state_o,
    output logic                   upd_o,
    output logic [$clog2(CH)-1:0]  upd_ch_o,
    output logic [DW-1:0]          upd_data_o,
    output logic                   sdo_o
);
    localparam int AW = $clog2(CH);
    localparam int KW = $clog2(DW + 1);

    fe_state_t     state_q, state_d;
    logic [KW-1:0] cnt_q;
    logic [AW-1:0] addr_q, addr_nx;
    logic [DW-1:0] rx_q, tx_q;
    logic          sdo_q;

    assign addr_nx = {sdi_i, addr_q[AW-1:1]};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = ST_HUNT;
            ST_HUNT: if (rise_i && sdi_i) state_d = ST_ADDR;
            ST_ADDR: if (rise_i && cnt_q == KW'(AW - 1)) state_d = ST_DATA;
            ST_DATA: if (rise_i && cnt_q == KW'(DW - 1)) state_d = ST_GAP;
            ST_GAP:  if (rise_i && cnt_q == KW'(GAP - 1)) state_d = ST_HUNT;
            default: state_d = ST_OFF;
        endcase
        if (!active_i) state_d = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            sdo_q  <= 1'b0;
        end else if (!active_i) begin
            cnt_q <= '0;
            sdo_q <= 1'b0;
        end else if (rise_i) begin
            unique case (state_q)
                ST_HUNT: cnt_q <= '0;
                ST_ADDR: begin
                    addr_q <= addr_nx;
                    if (cnt_q == KW'(AW - 1)) begin
                        cnt_q <= '0;
                        tx_q  <= bank_i[addr_nx*DW +: DW];
                        sdo_q <= bank_i[addr_nx*DW];
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    rx_q  <= {sdi_i, rx_q[DW-1:1]};
                    tx_q  <= tx_q >> 1;
                    sdo_q <= tx_q[1];
                    if (cnt_q == KW'(DW - 1)) begin
                        cnt_q <= '0;
                        sdo_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt_q == KW'(GAP - 1)) cnt_q <= '0;
                    else                       cnt_q <= cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    always_comb begin
        state_o    = state_q;
        upd_o      = active_i && rise_i && (state_q == ST_DATA) && (cnt_q == KW'(DW - 1));
        upd_ch_o   = addr_q;
        upd_data_o = {sdi_i, rx_q[DW-1:1]};
        sdo_o      = sdo_q;
    end
endmodule

// File: rtl/wsr_frontend.sv
module wsr_frontend
    import wsr_pkg::*;
#(
    parameter int CH      = 4,
    parameter int DW      = 8,
    parameter int GAP     = 2,
    parameter int STAGES  = 2,
    parameter int CS_FILT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             csel_i,
    input  logic             sdi_i,
    input  logic [CH*DW-1:0] nv_image_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic [CH*DW-1:0] wiper_o
);
    localparam int AW = $clog2(CH);

    logic          rise, sdi_s;
    logic          cs_sync, cs_f, cs_fall;
    fe_state_t     state;
    logic          upd;
    logic [AW-1:0] upd_ch;
    logic [DW-1:0] upd_data;
    logic [CH*DW-1:0] bank_q;

    wsr_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdi_i(sdi_i),
        .rise_o(rise), .sdi_o(sdi_s)
    );

    wsr_cs_filter #(.STAGES(STAGES), .CS_FILT(CS_FILT)) u_csf (
        .clk(clk), .rst_n(rst_n), .csel_i(csel_i),
        .cs_sync_o(cs_sync), .cs_o(cs_f), .fall_o(cs_fall)
    );

    wsr_frame_fsm #(.CH(CH), .DW(DW), .GAP(GAP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active_i(cs_f), .rise_i(rise), .sdi_i(sdi_s),
        .bank_i(bank_q), .state_o(state), .upd_o(upd), .upd_ch_o(upd_ch),
        .upd_data_o(upd_data), .sdo_o(sdo_o)
    );

    for (genvar k = 0; k < CH; k++) begin : g_wiper
        always_ff @(posedge clk) begin
            if (!rst_n || cs_fall)
                bank_q[k*DW +: DW] <= nv_image_i[k*DW +: DW];
            else if (upd && upd_ch == AW'(k))
                bank_q[k*DW +: DW] <= upd_data;
        end
    end

    assign wiper_o  = bank_q;
    assign sdo_oe_o = cs_f;
endmodule

// File: rtl/wsr_frontend_chk.sv
module wsr_frontend_chk
    import wsr_pkg::*;
#(
    parameter int CH = 4,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_sync,
    input logic             cs_f,
    input logic             cs_fall,
    input logic             rise,
    input logic             upd,
    input fe_state_t        state,
    input logic             sdo_o,
    input logic             sdo_oe_o,
    input logic [CH*DW-1:0] wiper_o,
    input logic [CH*DW-1:0] nv_image_i
);
    assert_oe_follows_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o == cs_f);

    assert_quiet_in_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT || state == ST_OFF) |-> !sdo_o);

    assert_reload_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> wiper_o == $past(nv_image_i));

    assert_filter_agrees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(cs_f) |-> $past(cs_sync) == cs_f);

    assert_wiper_moves_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(wiper_o) |-> ($past(upd) || $past(cs_fall)));

    assert_update_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> (rise && state == ST_DATA));
endmodule

bind wsr_frontend wsr_frontend_chk #(.CH(CH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_sync(cs_sync), .cs_f(cs_f), .cs_fall(cs_fall),
    .rise(rise), .upd(upd), .state(state), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .wiper_o(wiper_o), .nv_image_i(nv_image_i)
);

// File: tb/wsr_frontend_bench.sv
module wsr_frontend_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        csel = 1'b0;
    logic        sdi = 1'b0;
    logic [31:0] nv = 32'h44332211;
    logic        sdo, sdo_oe;
    logic [31:0] wiper;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_w [4];

    always #5 clk = ~clk;

    wsr_frontend u_wsr_frontend (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csel_i(csel), .sdi_i(sdi),
        .nv_image_i(nv), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wiper_o(wiper)
    );

    // entry: {channel index, write data, expected old value}
    localparam logic [17:0] VEC [6] = '{
        {2'd0, 8'hA5, 8'h11},
        {2'd1, 8'h3C, 8'h22},
        {2'd2, 8'hF0, 8'h33},
        {2'd3, 8'h01, 8'h44},
        {2'd0, 8'h5A, 8'hA5},
        {2'd2, 8'h00, 8'hF0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
        checks++;
        if (got !== want) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, want);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        sdi = b;
        wait_n(6);
        sclk = 1'b1;
        wait_n(8);
        sclk = 1'b0;
    endtask

    task automatic check_all(input string req);
        check(req, wiper, {exp_w[3], exp_w[2], exp_w[1], exp_w[0]});
    endtask

    task automatic frame(input logic [1:0] ch, input logic [7:0] wd, input logic [7:0] old);
        logic [7:0] got;
        got = '0;
        sbit(1'b1);
        sbit(ch[0]);
        sbit(ch[1]);
        got[0] = sdo;
        for (int i = 0; i < 8; i++) begin
            sbit(wd[i]);
            if (i < 7) got[i+1] = sdo;
        end
        check("R4 readback", {24'd0, got}, {24'd0, old});
        exp_w[ch] = wd;
        check_all("R3 R5 update");
        sbit(1'b1);
        sbit(1'b1);
    endtask

    task automatic set_cs(input logic v);
        csel = v;
        wait_n(12);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) exp_w[k] = nv[8*k +: 8];
        wait_n(4);
        check("R1 reset load", wiper, nv);
        rst_n = 1'b1;
        wait_n(2);
        check("R7 oe low at reset", {31'd0, sdo_oe}, 32'd0);

        set_cs(1'b1);
        check("R7 oe high", {31'd0, sdo_oe}, 32'd1);
        sbit(1'b0);
        sbit(1'b0);
        check("R7 sdo quiet in hunt", {31'd0, sdo}, 32'd0);
        for (int v = 0; v < 6; v++) frame(VEC[v][17:16], VEC[v][15:8], VEC[v][7:0]);
        check_all("R6 gap clocks ignored");

        set_cs(1'b0);
        for (int k = 0; k < 4; k++) exp_w[k] = nv[8*k +: 8];
        check("R8 reload on fall", wiper, nv);
        check("R7 oe low", {31'd0, sdo_oe}, 32'd0);

        csel = 1'b1;
        wait_n(2);
        csel = 1'b0;
        wait_n(12);
        check("R9 short pulse ignored", {31'd0, sdo_oe}, 32'd0);

        set_cs(1'b1);
        sbit(1'b1);
        sbit(1'b1);
        sbit(1'b0);
        for (int i = 0; i < 4; i++) sbit(1'b1);
        set_cs(1'b0);
        check("R10 abort keeps image", wiper, nv);
        set_cs(1'b1);
        frame(2'd1, 8'h77, 8'h22);
        set_cs(1'b0);
        check("R10 R8 reload after frame", wiper, nv);

        nv = 32'hC0FFEE42;
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        check("R1 power-on load", wiper, 32'hC0FFEE42);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule